// File: doc/BRIEF.md
# March Memory Self-Test Sequencer

This block is a built-in self-test engine for one single-port synchronous RAM. After a start pulse it walks a fixed table of march elements. Each element visits every address, either upward or downward. At each address it applies the element's short list of operations before stepping on. Writes put an all-zeros or all-ones background on the data bus. Reads are compared against the matching background one cycle later, which fits a RAM with one cycle of read latency.

Each mismatch produces a one-cycle fail strobe. The strobe carries the row and column of the address that was read, so a repair analyser can collect failing locations as they appear. When the last comparison has been made, the engine raises done. The pass flag then tells whether the whole run was clean. An optional repeat count makes each read issue several times back to back, which exposes cells whose contents are upset by being read.

Top module: `march_bist`

## Requirements
- R1: While reset is asserted and after it is released, done, pass, fail, write-enable and read-enable are all low.
- R2: The program holds 6 bits per element, with element 0 in the lowest bits. Bit 5 selects descending order. Bit 4 selects two operations instead of one. Bits 1:0 hold the first operation and bits 3:2 hold the second. Operation codes: 00 write 0, 01 write 1, 10 read 0, 11 read 1. The default program is: write 0 ascending; then read 0 and write 1 ascending; then read 1 descending.
- R3: An element applies all of its operations at one address before it moves to the next address. Ascending elements run from 0 to N-1 and descending elements from N-1 to 0. Exactly one memory operation is issued per cycle.
- R4: A write drives its data value on every bit of the write-data bus.
- R5: Read data is sampled on the cycle after the read and compared over the full width. A mismatch raises fail for one cycle, with the row (upper ROW_BITS of the address) and the column (lower COL_BITS) of that read.
- R6: Each read operation is issued RD_REPEAT times in consecutive cycles at the same address.
- R7: Done rises T+1 clock edges after the edge that accepts start, where T is the number of operations issued. Done then stays high, with no memory access, until the next start.
- R8: Pass is set when a run starts and is cleared by any mismatch in that run.
- R9: A start pulse while a run is in progress has no effect.
- R10: With the default program and RD_REPEAT=2, a stuck-at-0 cell, a stuck-at-1 cell, a cell that cannot rise from 0 to 1, and a cell upset by a read all end the run with pass low and with a fail report at that cell's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when idle or done |
| done_o | output | 1 | Run complete |
| pass_o | output | 1 | No mismatch seen in the current run |
| mem_addr_o | output | ROW_BITS+COL_BITS | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_wen_o | output | 1 | RAM write enable |
| mem_ren_o | output | 1 | RAM read enable |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the read |
| fail_o | output | 1 | Mismatch strobe |
| fail_row_o | output | ROW_BITS | Row of the failing read |
| fail_col_o | output | COL_BITS | Column of the failing read |

## Verification
A wrong element index, address counter or operation index appears at once on the address and enable pins. The bench checks the whole access stream against the expected order, so such an error is caught on the first access that goes astray. A corrupted repeat counter changes the number of reads at an address and shifts the run length, which the done timing exposes. A wrong compare pipeline shows up as fail strobes on the wrong cycle or with the wrong row and column. It also shows as a fail count that differs from the value worked out for each injected fault.

// File: rtl/march_bist.sv
module march_bist #(
  parameter int ROW_BITS  = 3,
  parameter int COL_BITS  = 2,
  parameter int DATA_W    = 8,
  parameter int NUM_ELEM  = 3,
  parameter int RD_REPEAT = 1,
  parameter logic [6*NUM_ELEM-1:0] PROGRAM = {6'b100011, 6'b010110, 6'b000000}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  output logic                          done_o,
  output logic                          pass_o,
  output logic [ROW_BITS+COL_BITS-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  output logic                          mem_wen_o,
  output logic                          mem_ren_o,
  input  logic [DATA_W-1:0]             mem_rdata_i,
  output logic                          fail_o,
  output logic [ROW_BITS-1:0]           fail_row_o,
  output logic [COL_BITS-1:0]           fail_col_o
);
  localparam int AW = ROW_BITS + COL_BITS;
  localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};
  localparam int EW = $clog2(NUM_ELEM + 1);
  localparam int RW = $clog2(RD_REPEAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_t;

  state_t         st;
  logic [EW-1:0]  elem;
  logic [AW-1:0]  addr;
  logic           opi;
  logic [RW-1:0]  rep;
  logic           chk_vld, chk_exp, pass_r;
  logic [AW-1:0]  chk_addr;

  function automatic logic [AW-1:0] entry_addr(input int e);
    return PROGRAM[6*e+5] ? ADDR_TOP : '0;
  endfunction

  logic [5:0] cur;
  logic [1:0] op;
  assign cur = PROGRAM[6*int'(elem) +: 6];
  assign op  = opi ? cur[3:2] : cur[1:0];

  wire run       = (st == S_RUN);
  wire is_rd     = op[1];
  wire last_rep  = !is_rd || (rep == RW'(RD_REPEAT - 1));
  wire last_op   = !cur[4] || opi;
  wire addr_end  = cur[5] ? (addr == '0) : (addr == ADDR_TOP);
  wire last_elem = (elem == EW'(NUM_ELEM - 1));
  wire mismatch  = chk_vld && (mem_rdata_i != {DATA_W{chk_exp}});

  assign mem_addr_o  = addr;
  assign mem_wen_o   = run && !is_rd;
  assign mem_ren_o   = run && is_rd;
  assign mem_wdata_o = {DATA_W{op[0]}};
  assign fail_o      = mismatch;
  assign fail_row_o  = chk_addr[AW-1:COL_BITS];
  assign fail_col_o  = chk_addr[COL_BITS-1:0];
  assign done_o      = (st == S_DONE);
  assign pass_o      = pass_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      elem     <= '0;
      addr     <= '0;
      opi      <= 1'b0;
      rep      <= '0;
      chk_vld  <= 1'b0;
      chk_exp  <= 1'b0;
      chk_addr <= '0;
      pass_r   <= 1'b0;
    end else begin
      chk_vld  <= mem_ren_o;
      chk_exp  <= op[0];
      chk_addr <= addr;
      if (mismatch) pass_r <= 1'b0;
      case (st)
        S_IDLE, S_DONE: if (start_i) begin
          st     <= S_RUN;
          elem   <= '0;
          addr   <= entry_addr(0);
          opi    <= 1'b0;
          rep    <= '0;
          pass_r <= 1'b1;
        end
        S_RUN: begin
          if (!last_rep) rep <= rep + 1'b1;
          else begin
            rep <= '0;
            if (!last_op) opi <= 1'b1;
            else begin
              opi <= 1'b0;
              if (!addr_end) addr <= cur[5] ? addr - 1'b1 : addr + 1'b1;
              else if (last_elem) st <= S_DRAIN;
              else begin
                elem <= elem + 1'b1;
                addr <= entry_addr(int'(elem) + 1);
              end
            end
          end
        end
        S_DRAIN: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wen_o && mem_ren_o));
  a_r4_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wen_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1));
  a_r5_fail_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> $past(mem_ren_o));
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_wen_o && !mem_ren_o));
  a_r8_fail_drops_pass: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !pass_o);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(last_rep && last_op && addr_end && last_elem)) |=> run);
endmodule

// File: tb/tb_march_bist.sv
module tb_march_bist;
  localparam int RB = 3, CB = 2, DW = 8, N = 32, RD = 2;
  localparam int T = N * 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic done, pass, wen, ren, fail;
  logic [4:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [RB-1:0] frow;
  logic [CB-1:0] fcol;

  always #2 clk = ~clk;

  march_bist #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .RD_REPEAT(RD)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .pass_o(pass),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_wen_o(wen), .mem_ren_o(ren),
    .mem_rdata_i(rdata), .fail_o(fail), .fail_row_o(frow), .fail_col_o(fcol));

  int nchk = 0, nerr = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fault kinds: 0 none, 1 stuck-0, 2 stuck-1, 3 read-upset, 4 no 0->1
  logic [DW-1:0] mem [N];
  int fk = 0, fa = 0, fb = 0;
  always @(posedge clk) begin : ram
    logic [DW-1:0] rd, w;
    if (ren) begin
      rd = mem[addr];
      if (fk == 1 && addr == fa) rd[fb] = 1'b0;
      if (fk == 2 && addr == fa) rd[fb] = 1'b1;
      rdata <= rd;
      if (fk == 3 && addr == fa) mem[addr][fb] <= ~mem[addr][fb];
    end
    if (wen) begin
      w = wdata;
      if (fk == 4 && addr == fa && !mem[addr][fb]) w[fb] = 1'b0;
      mem[addr] <= w;
    end
  end

  int acc = 0, bad_seq = 0, nfail = 0, frow_1st = 0, fcol_1st = 0;
  always @(negedge clk) begin
    if (wen || ren) begin
      int k, a, o;
      bit ew, er;
      logic [DW-1:0] ed;
      if (acc < N) begin a = acc; ew = 1; er = 0; ed = '0; end
      else if (acc < 4*N) begin
        k = acc - N; a = k / 3; o = k % 3;
        ew = (o == 2); er = (o != 2); ed = '1;
      end else begin
        k = acc - 4*N; a = N - 1 - k / 2; ew = 0; er = 1; ed = '0;
      end
      if (acc >= T || addr != a[4:0] || wen != ew || ren != er || (ew && wdata != ed))
        bad_seq++;
      acc++;
    end
    if (fail) begin
      if (nfail == 0) begin frow_1st = frow; fcol_1st = fcol; end
      nfail++;
    end
  end

  // {kind, addr, bit, fails, pass}
  localparam logic [14:0] VEC [6] = '{
    {3'd0, 5'd0,  3'd0, 3'd0, 1'b1},
    {3'd1, 5'd5,  3'd7, 3'd2, 1'b0},
    {3'd2, 5'd30, 3'd0, 3'd2, 1'b0},
    {3'd3, 5'd0,  3'd3, 3'd2, 1'b0},
    {3'd4, 5'd17, 3'd4, 3'd2, 1'b0},
    {3'd1, 5'd31, 3'd0, 3'd2, 1'b0}
  };

  initial begin
    #(4 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !pass && !wen && !ren && !fail, "R1 reset outputs", {done, pass, wen, ren}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!done && !pass && !wen && !ren, "R1 after reset", {done, pass, wen, ren}, 0);

    for (int v = 0; v < 6; v++) begin
      int cyc;
      fk = VEC[v][14:12]; fa = VEC[v][11:7]; fb = VEC[v][6:4];
      for (int i = 0; i < N; i++) mem[i] = 8'hA5;
      nfail = 0; bad_seq = 0;
      start = 1;
      @(posedge clk);
      acc = 0;
      @(negedge clk);
      start = 0;
      cyc = 0;
      while (!done && cyc < 1000) begin
        if (v == 0) start = (cyc == 50);
        @(posedge clk); cyc++;
        @(negedge clk);
      end
      start = 0;
      check(cyc == T + 1, "R7 R9 R6 run length", cyc, T + 1);
      check(bad_seq == 0, "R2 R3 R4 R6 access order", bad_seq, 0);
      check(pass == VEC[v][0], "R8 R10 pass flag", pass, VEC[v][0]);
      check(nfail == VEC[v][3:1], "R5 R10 fail count", nfail, VEC[v][3:1]);
      if (VEC[v][3:1] != 0) begin
        check(frow_1st == fa / 4, "R5 fail row", frow_1st, fa / 4);
        check(fcol_1st == fa % 4, "R5 fail col", fcol_1st, fa % 4);
      end
      repeat (4) @(negedge clk);
      check(done && !wen && !ren && acc == T, "R7 done holds quiet", acc, T);
    end

    fk = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    check(!done && pass && (wen || ren), "R8 running after restart", {done, pass}, 1);
    rst_n = 0;
    @(negedge clk);
    check(!done && !pass && !wen && !ren, "R1 reset mid-run", {done, pass, wen, ren}, 0);
    rst_n = 1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule